// File: doc/BRIEF.md
# Time-Multiplexed Space Switch Stage

This block is the space stage of a digital switching fabric. It takes a set of synchronous TDM lines, each carrying one sample per time slot. In every slot it connects them to the same number of output lines through a crossbar, and the crossbar pattern can be different in every slot of the frame. A slot counter shared by all lines indexes a control table. The table holds one entry per line per slot, and each entry is a valid bit plus a line number. All outputs leave through a single registered bus, one clock after the slot in which their inputs arrived.

A build parameter sets how the table is organised. In output-keyed mode, each output line owns a column of entries, and each entry names the input that feeds that output. In input-keyed mode, each input line owns the column, and each entry names the output that the input drives. Input-keyed mode can ask for two inputs on one output. In that case the lower-numbered input gets the output, and a contention flag marks the slot. Outputs that nothing drives carry an all-ones idle pattern.

A host writes entries into a shadow copy of the table. The whole shadow copy becomes the working table at the next frame boundary, so a connection map always changes between frames and never partway through one. A frame-sync input realigns the slot counter to the start of a frame.

Top module: `tss_space_switch`

## Requirements
- R1: While reset is asserted, every output lane holds all ones, `conflict` is 0 and `slotNum` is 0.
- R2: `slotNum` advances by one on each clock and returns to 0 after the value SLOTS-1.
- R3: When `frameSync` is high in a cycle, `slotNum` is 0 in the next cycle, and counting continues from there.
- R4: In output-keyed mode, an entry for output o and slot k has its valid bit (bit LW) set and an input number i in bits [LW-1:0]. Output lane o (bits [o*W +: W] of `outData`) then carries the sample of input lane i one cycle after the cycle in which `slotNum` is k. Each slot uses its own entry, so connections can differ from one slot to the next.
- R5: In output-keyed mode, an output whose entry for the slot has a clear valid bit carries all ones.
- R6: In input-keyed mode, a valid entry for input i and slot k that names output o puts input lane i on output lane o, with the same one-cycle timing as R4.
- R7: In input-keyed mode, an output named by no valid entry in the slot carries all ones.
- R8: In input-keyed mode, when two or more inputs name the same output in a slot, the lowest-numbered of them drives that output. `conflict` is 1 in the same cycle as that slot's outputs. It is 0 for slots with no contention.
- R9: Host writes go into the shadow table. The working table takes the shadow contents only at the clock edge that ends slot SLOTS-1 or a `frameSync` cycle. A write accepted at that same edge waits for the following boundary. Outside those edges the working table does not change.
- R10: In output-keyed mode, one input can feed several outputs in the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one slot per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| frameSync | input | 1 | Makes the next cycle slot 0 and commits the shadow table |
| inData | input | LINES*W | Input samples, lane i at [i*W +: W] |
| hostWrEn | input | 1 | Host write strobe for the shadow table |
| hostLine | input | LW | Line column to write |
| hostSlot | input | SW | Slot row to write |
| hostEntry | input | LW+1 | Entry: valid in bit LW, line number below |
| slotNum | output | SW | Current slot of the inputs |
| outData | output | LINES*W | Registered switched samples, lane o at [o*W +: W] |
| conflict | output | 1 | Registered contention flag for the slot on outData |

## Verification
The bench builds two copies side by side with 4 lines, 8 slots and 8-bit samples, one in each control mode. Both copies share the same inputs and frame timing. The short 8-slot frame lets a single test program both tables completely and pass several frame boundaries. Within one frame it shows per-slot pattern changes, idle outputs, broadcast, and lowest-input-wins contention. It also shows a host write that stays invisible until the boundary after it is made, and a frame-sync realignment in the middle of a frame.

// File: rtl/tss_pkg.sv
package tss_pkg;

  typedef enum logic {
    CTRL_BY_OUTPUT = 1'b0,
    CTRL_BY_INPUT  = 1'b1
  } ctrlMode_e;

  typedef struct packed {
    logic shadowWr;
    logic commit;
  } tssStrobe_t;

endpackage

// File: rtl/tss_ctrl.sv
module tss_ctrl
  import tss_pkg::*;
#(
  parameter int SLOTS = 128
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     frameSync,
  input  logic                     hostWrEn,
  output logic [$clog2(SLOTS)-1:0] slotNow,
  output tssStrobe_t               strobe
);
  localparam int SW = $clog2(SLOTS);

  logic lastSlot;
  assign lastSlot = (slotNow == SW'(SLOTS - 1));

  assign strobe.commit   = lastSlot | frameSync;
  assign strobe.shadowWr = hostWrEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              slotNow <= '0;
    else if (strobe.commit) slotNow <= '0;
    else                    slotNow <= slotNow + 1'b1;
  end

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (slotNow == SW'(SLOTS - 1)) |=> (slotNow == '0)); // R2
  AST_SYNC_REALIGN: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> (slotNow == '0)); // R3

endmodule

// File: rtl/tss_datapath.sv
module tss_datapath
  import tss_pkg::*;
#(
  parameter int        LINES    = 16,
  parameter int        SLOTS    = 128,
  parameter int        SAMPLE_W = 8,
  parameter ctrlMode_e MODE     = CTRL_BY_OUTPUT
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  tssStrobe_t                  strobe,
  input  logic [$clog2(SLOTS)-1:0]    slotNow,
  input  logic [$clog2(LINES)-1:0]    wrLine,
  input  logic [$clog2(SLOTS)-1:0]    wrSlot,
  input  logic [$clog2(LINES):0]      wrEntry,
  input  logic [LINES*SAMPLE_W-1:0]   inBus,
  output logic [LINES*SAMPLE_W-1:0]   outBus,
  output logic                        conflict
);
  localparam int LW = $clog2(LINES);
  localparam int EW = LW + 1;

  logic [EW-1:0]       shadowMem [LINES][SLOTS];
  logic [EW-1:0]       activeMem [LINES][SLOTS];
  logic [EW-1:0]       curEntry  [LINES];
  logic [SAMPLE_W-1:0] inSample  [LINES];
  logic [SAMPLE_W-1:0] nextOut   [LINES];
  logic                nextConflict;

  // shadow table written by the host
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < LINES; l++)
        for (int s = 0; s < SLOTS; s++)
          shadowMem[l][s] <= '0;
    end else if (strobe.shadowWr) begin
      shadowMem[wrLine][wrSlot] <= wrEntry;
    end
  end

  // working table, replaced whole at a frame boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int l = 0; l < LINES; l++)
        for (int s = 0; s < SLOTS; s++)
          activeMem[l][s] <= '0;
    end else if (strobe.commit) begin
      activeMem <= shadowMem;
    end
  end

  always_comb begin
    for (int l = 0; l < LINES; l++) begin
      curEntry[l] = activeMem[l][slotNow];
      inSample[l] = inBus[l*SAMPLE_W +: SAMPLE_W];
    end
  end

  generate
    if (MODE == CTRL_BY_OUTPUT) begin : g_outKeyed
      always_comb begin
        nextConflict = 1'b0;
        for (int o = 0; o < LINES; o++) begin
          nextOut[o] = '1;
          if (curEntry[o][LW]) nextOut[o] = inSample[curEntry[o][LW-1:0]];
        end
      end
      for (genvar o = 0; o < LINES; o++) begin : g_idleChk
        AST_IDLE_ON_INVALID: assert property (@(posedge clk) disable iff (!rstN)
          !curEntry[o][LW] |=> (outBus[o*SAMPLE_W +: SAMPLE_W] == '1)); // R5
      end
    end else begin : g_inKeyed
      logic [LINES-1:0] hitSeen;
      always_comb begin
        nextConflict = 1'b0;
        hitSeen      = '0;
        for (int o = 0; o < LINES; o++) begin
          nextOut[o] = '1;
          // scan downward so the lowest-numbered claimant is kept
          for (int i = LINES - 1; i >= 0; i--) begin
            if (curEntry[i][LW] && (curEntry[i][LW-1:0] == LW'(o))) begin
              if (hitSeen[o]) nextConflict = 1'b1;
              hitSeen[o] = 1'b1;
              nextOut[o] = inSample[i];
            end
          end
        end
      end
      AST_NO_CLAIM_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
        (hitSeen == '0) |=> !conflict); // R8
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outBus   <= '1;
      conflict <= 1'b0;
    end else begin
      for (int o = 0; o < LINES; o++) outBus[o*SAMPLE_W +: SAMPLE_W] <= nextOut[o];
      conflict <= nextConflict;
    end
  end

  for (genvar l = 0; l < LINES; l++) begin : g_holdChk
    AST_TABLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.commit |=> $stable(activeMem[l][0])); // R9
  end

endmodule

// File: rtl/tss_space_switch.sv
module tss_space_switch
  import tss_pkg::*;
#(
  parameter int        LINES    = 16,
  parameter int        SLOTS    = 128,
  parameter int        SAMPLE_W = 8,
  parameter ctrlMode_e MODE     = CTRL_BY_OUTPUT
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      frameSync,
  input  logic [LINES*SAMPLE_W-1:0] inData,
  input  logic                      hostWrEn,
  input  logic [$clog2(LINES)-1:0]  hostLine,
  input  logic [$clog2(SLOTS)-1:0]  hostSlot,
  input  logic [$clog2(LINES):0]    hostEntry,
  output logic [$clog2(SLOTS)-1:0]  slotNum,
  output logic [LINES*SAMPLE_W-1:0] outData,
  output logic                      conflict
);
  tssStrobe_t strobe;

  tss_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .hostWrEn(hostWrEn),
    .slotNow(slotNum), .strobe(strobe)
  );

  tss_datapath #(.LINES(LINES), .SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W), .MODE(MODE)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotNow(slotNum),
    .wrLine(hostLine), .wrSlot(hostSlot), .wrEntry(hostEntry),
    .inBus(inData), .outBus(outData), .conflict(conflict)
  );

endmodule

// File: tb/tss_space_switch_test.sv
module tss_space_switch_test;
  import tss_pkg::*;

  localparam int LINES = 4;
  localparam int SLOTS = 8;
  localparam int W     = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, frameSync, hostWrO, hostWrI;
  logic [LINES*W-1:0] inData;
  logic [1:0] hostLine;
  logic [2:0] hostSlot, hostEntry;
  logic [2:0] slotO, slotI;
  logic [LINES*W-1:0] outO, outI;
  logic confO, confI;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [2:0] tblO [LINES][SLOTS];
  logic [2:0] tblI [LINES][SLOTS];

  tss_space_switch #(.LINES(LINES), .SLOTS(SLOTS), .SAMPLE_W(W), .MODE(CTRL_BY_OUTPUT)) uut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .inData(inData), .hostWrEn(hostWrO),
    .hostLine(hostLine), .hostSlot(hostSlot), .hostEntry(hostEntry),
    .slotNum(slotO), .outData(outO), .conflict(confO));

  tss_space_switch #(.LINES(LINES), .SLOTS(SLOTS), .SAMPLE_W(W), .MODE(CTRL_BY_INPUT)) uutIn (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .inData(inData), .hostWrEn(hostWrI),
    .hostLine(hostLine), .hostSlot(hostSlot), .hostEntry(hostEntry),
    .slotNum(slotI), .outData(outI), .conflict(confI));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] sample(int i, int s);
    return 8'(16 * i + s + 1);
  endfunction

  function automatic logic [7:0] expOut(int o, int s);
    return tblO[o][s][2] ? sample(int'(tblO[o][s][1:0]), s) : 8'hFF;
  endfunction

  function automatic logic [7:0] expIn(int o, int s);
    logic [7:0] r = 8'hFF;
    for (int i = LINES - 1; i >= 0; i--)
      if (tblI[i][s][2] && tblI[i][s][1:0] == 2'(o)) r = sample(i, s);
    return r;
  endfunction

  function automatic bit claimed(int o, int s);
    for (int i = 0; i < LINES; i++)
      if (tblI[i][s][2] && tblI[i][s][1:0] == 2'(o)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic expConf(int s);
    for (int o = 0; o < LINES; o++) begin
      int n = 0;
      for (int i = 0; i < LINES; i++)
        if (tblI[i][s][2] && tblI[i][s][1:0] == 2'(o)) n++;
      if (n > 1) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic waitFrameStart();
    while (slotO != 3'(SLOTS - 1)) @(negedge clk);
    @(negedge clk);
  endtask

  // one full frame starting at slot 0; optional host write during slot 0
  task automatic runFrame(bit pend, int fo, int fs, logic [2:0] pe, string focusTag);
    for (int s = 0; s < SLOTS; s++) begin
      chk("R2", 32'(slotO), 32'(s));
      for (int i = 0; i < LINES; i++) inData[i*W +: W] = sample(i, s);
      if (pend && s == 0) begin
        hostLine = 2'(fo); hostSlot = 3'(fs); hostEntry = pe; hostWrO = 1'b1;
      end
      @(negedge clk);
      hostWrO = 1'b0;
      for (int o = 0; o < LINES; o++) begin
        string tagO = tblO[o][s][2] ? "R4" : "R5";
        if (pend && o == fo && s == fs) tagO = focusTag;
        chk(tagO, 32'(outO[o*W +: W]), 32'(expOut(o, s)));
        chk(claimed(o, s) ? "R6" : "R7", 32'(outI[o*W +: W]), 32'(expIn(o, s)));
      end
      chk("R8", 32'(confI), 32'(expConf(s)));
      if (s == 5) chk("R8", 32'(outI[1*W +: W]), 32'(sample(0, 5)));
      if (s == 4) chk("R10", 32'(outO[1*W +: W]), 32'(outO[2*W +: W]));
    end
  endtask

  task automatic testReset();
    chk("R1", 32'(outO), 32'hFFFF_FFFF);
    chk("R1", 32'(outI), 32'hFFFF_FFFF);
    chk("R1", 32'(confI), 32'd0);
    chk("R1", 32'(slotO), 32'd0);
  endtask

  task automatic testProgramAndSwitch();
    for (int s = 0; s < SLOTS; s++) begin
      tblO[0][s] = {1'b1, 2'(s % 4)};
      tblO[1][s] = (s == 3) ? 3'b000 : 3'b110;
      tblO[2][s] = 3'b110;
      tblO[3][s] = 3'b000;
      tblI[0][s] = {1'b1, 2'(s % 4)};
      tblI[1][s] = (s % 2 == 0) ? {1'b1, 2'((s + 1) % 4)} : 3'b000;
      tblI[2][s] = (s == 6) ? 3'b111 : 3'b000;
      tblI[3][s] = (s == 5) ? 3'b101 : 3'b000;
    end
    for (int l = 0; l < LINES; l++)
      for (int s = 0; s < SLOTS; s++) begin
        hostLine = 2'(l); hostSlot = 3'(s);
        hostEntry = tblO[l][s]; hostWrO = 1'b1;
        @(negedge clk);
        hostWrO = 1'b0;
        hostEntry = tblI[l][s]; hostWrI = 1'b1;
        @(negedge clk);
        hostWrI = 1'b0;
      end
    waitFrameStart();
    runFrame(1'b0, 0, 0, 3'b000, "R4");
  endtask

  task automatic testDeferredWrite();
    // new entry for output 3, slot 7: old (idle) for this frame, new next frame
    runFrame(1'b1, 3, 7, 3'b101, "R9");
    tblO[3][7] = 3'b101;
    runFrame(1'b0, 0, 0, 3'b000, "R9");
    chk("R9", 32'(tblO[3][7]), 32'(3'b101));
  endtask

  task automatic testFrameSync();
    repeat (3) @(negedge clk);
    chk("R3", 32'(slotO), 32'd3);
    frameSync = 1'b1;
    @(negedge clk);
    frameSync = 1'b0;
    chk("R3", 32'(slotO), 32'd0);
    @(negedge clk);
    chk("R3", 32'(slotI), 32'd1);
  endtask

  initial begin
    rstN = 1'b0; frameSync = 1'b0; hostWrO = 1'b0; hostWrI = 1'b0;
    inData = '0; hostLine = '0; hostSlot = '0; hostEntry = '0;
    repeat (2) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testProgramAndSwitch();
    testDeferredWrite();
    testFrameSync();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule